// File: doc/BRIEF.md
# Touch and Sensor Conversion Scheduler

This block is the sequencing and status core of a resistive touch panel and sensor ADC controller. Software programs a requested conversion function, a result resolution and an enable through a control word. The block then decides, every clock cycle, whether a conversion set may begin. That decision depends on the requested function, on whether the pen is touching the panel, and on whether earlier results are still unread. A started set keeps the block busy for a fixed number of cycles. When the set finishes, the block raises the data-available flags that belong to that function.

Results are read through a small register port. Data-page reads return the 16-bit raw sample presented on `sample_in`, right-shifted to the resolution latched when the conversion started. Each result read clears its own flag. An active-low interrupt line follows one of several conditions, chosen by a pin-function field in the status word. A write of a magic value to the reset register returns the block to its power-up state.

The register address is `{page, offset}`. Page 0 holds the data registers. Page 1 holds control: offset 0 is the conversion control word, 1 is status, 3 is the reference field, 4 is soft reset and 5 is the timing configuration field.

Top module: `touch_conv_ctrl`

## Requirements
- R1: After reset, the status word reads 0xA000 (pin function 2, not enabled, no flags), the control word reads 0x4000 with the pen up, and `irq_n` is 1.
- R2: A control write stores host mode from bit 15, enable as the inverse of bit 14, the function from bits 13:10, the resolution from bits 9:8 and the filter from bits 7:0. A control read returns pen down in bit 15, not-busy in bit 14, and the stored function, resolution and filter in bits 13:0.
- R3: A status read returns the pin function in bits 15:14, not-enabled in bit 13, host mode in bit 12, the OR of all flags in bit 11 and the flags in bits 10:0. A status write changes only the pin function, which it takes from bits 15:14.
- R4: A finished conversion ORs in a flag mask chosen by the function code:
  - 1 gives 0x600 and 2 gives 0x780.
  - 3 gives 0x400, 4 gives 0x200 and 5 gives 0x180.
  - 6 gives 0x040 and 7 gives 0x030.
  - 8 and 9 each give 0x010.
  - 10 gives 0x004, 11 gives 0x070 and 12 gives 0x002.
- R5: Functions 1 to 5 start only while the pen is down. Functions 9 and 11 start regardless of the pen. Functions 0 and 13 to 15 never start.
- R6: For the single-shot functions 3 to 8, 10 and 12, any set flag blocks a start and clears the enable.
- R7: A start needs the block enabled and idle. It is evaluated on the cycle after the control write and latches the function and resolution. It holds busy for CONV_CYCLES cycles, then sets the flags.
- R8: A read of data offset k clears one flag. For k from 0 to 3 it clears bit 10-k. For k from 5 to 11 it clears bit 11-k. Offset 4 clears nothing.
- R9: A data read returns `sample_in` shifted right by 4, 8, 6 or 4 bits for resolution codes 0, 1, 2 and 3. Offsets 4, 8, 11 and above 11 read 0xFFFF.
- R10: `irq_n` is active low. Pin function 0 asserts it while the pen is down. Function 1 asserts it while any flag is set. Functions 2 and 3 assert it while the pen is down with no flag set. It is never asserted while the block is disabled.
- R11: Writing 0xBB00 to the reset register restores the R1 state and clears the reference and configuration fields. Any other value written there changes nothing.
- R12: A control write with bit 14 set clears the enable and cancels a running conversion, so no flags are set for it.
- R13: The reference register keeps the low 5 bits of a write and the configuration register keeps the low 6 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pen_in | input | 1 | Pen touching the panel, registered once inside |
| sample_in | input | 16 | Raw 16-bit sample for the data register being addressed |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; the clear-on-read takes effect at the edge |
| addr | input | 5 | Bit 4 is the page (0 data, 1 control), bits 3:0 the offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A start gate that is wrong, or a stale busy bit, shows up on the control word's not-busy bit one cycle after the enabling write. It then shows up CONV_CYCLES+1 cycles later as missing or extra flags in the status word. A flag register that clears wrongly shows up on the status read right after a data read. Because `irq_n` is driven combinationally from the flags, enable and registered pen state, a wrong flag also shows up on the interrupt line within the same cycle.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FLAG_W = 11;
  localparam int unsigned FN_W   = 4;
  localparam int unsigned RES_W  = 2;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned ADDR_W = OFF_W + 1;

  typedef enum logic [2:0] {
    ST_NEVER,
    ST_PEN,
    ST_PEN_ONCE,
    ST_ONCE,
    ST_FREE
  } start_rule_e;

  function automatic start_rule_e rule_of(input logic [FN_W-1:0] fn);
    case (fn)
      4'd1, 4'd2:                      rule_of = ST_PEN;
      4'd3, 4'd4, 4'd5:                rule_of = ST_PEN_ONCE;
      4'd6, 4'd7, 4'd8, 4'd10, 4'd12:  rule_of = ST_ONCE;
      4'd9, 4'd11:                     rule_of = ST_FREE;
      default:                         rule_of = ST_NEVER;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] mask_of(input logic [FN_W-1:0] fn);
    case (fn)
      4'd1:        mask_of = 11'h600;
      4'd2:        mask_of = 11'h780;
      4'd3:        mask_of = 11'h400;
      4'd4:        mask_of = 11'h200;
      4'd5:        mask_of = 11'h180;
      4'd6:        mask_of = 11'h040;
      4'd7:        mask_of = 11'h030;
      4'd8, 4'd9:  mask_of = 11'h010;
      4'd10:       mask_of = 11'h004;
      4'd11:       mask_of = 11'h070;
      4'd12:       mask_of = 11'h002;
      default:     mask_of = '0;
    endcase
  endfunction

  function automatic logic [3:0] shift_of(input logic [RES_W-1:0] res);
    case (res)
      2'd1:    shift_of = 4'd8;
      2'd2:    shift_of = 4'd6;
      default: shift_of = 4'd4;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] clear_of(input logic [OFF_W-1:0] off);
    clear_of = '0;
    if (off < 4'd4)
      clear_of[4'd10 - off] = 1'b1;
    else if (off >= 4'd5 && off <= 4'd11)
      clear_of[4'd11 - off] = 1'b1;
  endfunction
endpackage

// File: rtl/tcc_regs.sv
module tcc_regs
  import tcc_pkg::*;
#(
  parameter int unsigned REF_W = 5,
  parameter int unsigned CFG_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic                host_q,
  output logic [FN_W-1:0]     fn_q,
  output logic [RES_W-1:0]    res_q,
  output logic [7:0]          filt_q,
  output logic [1:0]          pin_fn_q,
  output logic [REF_W-1:0]    ref_q,
  output logic [CFG_W-1:0]    cfg_q,
  output logic                ctl_wr,
  output logic                ctl_stop,
  output logic                soft_rst
);
  localparam logic [WORD_W-1:0] RESET_KEY = 16'hBB00;
  localparam logic [1:0]        PIN_FN_RST = 2'd2;

  logic [OFF_W-1:0] off;
  logic             ctl_page;
  logic             stat_wr, ref_wr, cfg_wr;

  assign off      = addr[OFF_W-1:0];
  assign ctl_page = addr[OFF_W];
  assign ctl_wr   = wr_en && ctl_page && (off == 4'd0);
  assign stat_wr  = wr_en && ctl_page && (off == 4'd1);
  assign ref_wr   = wr_en && ctl_page && (off == 4'd3);
  assign soft_rst = wr_en && ctl_page && (off == 4'd4) && (wdata == RESET_KEY);
  assign cfg_wr   = wr_en && ctl_page && (off == 4'd5);
  assign ctl_stop = wdata[14];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q   <= 1'b0;
      fn_q     <= '0;
      res_q    <= '0;
      filt_q   <= '0;
      pin_fn_q <= PIN_FN_RST;
      ref_q    <= '0;
      cfg_q    <= '0;
    end else if (soft_rst) begin
      host_q   <= 1'b0;
      fn_q     <= '0;
      res_q    <= '0;
      filt_q   <= '0;
      pin_fn_q <= PIN_FN_RST;
      ref_q    <= '0;
      cfg_q    <= '0;
    end else begin
      if (ctl_wr) begin
        host_q <= wdata[15];
        fn_q   <= wdata[13:10];
        res_q  <= wdata[9:8];
        filt_q <= wdata[7:0];
      end
      if (stat_wr) pin_fn_q <= wdata[15:14];
      if (ref_wr)  ref_q    <= wdata[REF_W-1:0];
      if (cfg_wr)  cfg_q    <= wdata[CFG_W-1:0];
    end
  end

  p_soft_reset_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (pin_fn_q == PIN_FN_RST) && (fn_q == '0) && (ref_q == '0));
endmodule

// File: rtl/tcc_sequencer.sv
module tcc_sequencer
  import tcc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pen,
  input  logic [FN_W-1:0]    next_fn,
  input  logic [RES_W-1:0]   next_res,
  input  logic               ctl_wr,
  input  logic               ctl_stop,
  input  logic               soft_rst,
  input  logic [FLAG_W-1:0]  flag_clr,
  output logic               en_q,
  output logic               busy_q,
  output logic [RES_W-1:0]   res_q,
  output logic [FLAG_W-1:0]  flags_q
);
  localparam int unsigned CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

  start_rule_e       rule;
  logic              mode_ok, once, launch;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FN_W-1:0]   fn_q;
  logic              en_d, busy_d;
  logic [FLAG_W-1:0] flags_d;

  always_comb begin
    rule = rule_of(next_fn);
    once = (rule == ST_PEN_ONCE) || (rule == ST_ONCE);
    case (rule)
      ST_PEN, ST_PEN_ONCE: mode_ok = pen;
      ST_ONCE, ST_FREE:    mode_ok = 1'b1;
      default:             mode_ok = 1'b0;
    endcase
    launch = en_q && !busy_q && mode_ok && !(once && (|flags_q)) && !ctl_wr && !soft_rst;
  end

  always_comb begin
    en_d    = en_q;
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    flags_d = flags_q & ~flag_clr;
    if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d  = 1'b0;
        flags_d = flags_d | mask_of(fn_q);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end else if (launch) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LAST;
    end
    if (ctl_wr) begin
      en_d = !ctl_stop;
      if (ctl_stop) begin
        busy_d  = 1'b0;
        flags_d = flags_q & ~flag_clr;
      end
    end else if (once && (|flags_q)) begin
      en_d = 1'b0;
    end
    if (soft_rst) begin
      en_d    = 1'b0;
      busy_d  = 1'b0;
      cnt_d   = '0;
      flags_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      flags_q <= '0;
    end else begin
      en_q    <= en_d;
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fn_q  <= '0;
      res_q <= '0;
    end else if (launch) begin
      fn_q  <= next_fn;
      res_q <= next_res;
    end
  end

  p_start_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(en_q));
  p_flags_hold_without_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(soft_rst) && ($past(flag_clr) == '0)) |-> ((flags_q & $past(flags_q)) == $past(flags_q)));
  p_finish_sets_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(soft_rst) && !$past(ctl_wr)) |-> ((flags_q & mask_of(fn_q)) == mask_of(fn_q)));
  p_stop_cancels_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_stop) |=> (!busy_q && !en_q));
endmodule

// File: rtl/tcc_irq.sv
module tcc_irq
  import tcc_pkg::*;
(
  input  logic        pen,
  input  logic        en,
  input  logic        any_flag,
  input  logic [1:0]  pin_fn,
  output logic        irq_n
);
  logic cond;

  always_comb begin
    case (pin_fn)
      2'd0:    cond = pen;
      2'd1:    cond = any_flag;
      default: cond = pen && !any_flag;
    endcase
    irq_n = !(cond && en);
  end
endmodule

// File: rtl/touch_conv_ctrl.sv
module touch_conv_ctrl
  import tcc_pkg::*;
#(
  parameter int unsigned CONV_CYCLES = 8,
  parameter int unsigned REF_W       = 5,
  parameter int unsigned CFG_W       = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pen_in,
  input  logic [WORD_W-1:0]    sample_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 irq_n
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic              pen_q;
  logic              host, ctl_wr, ctl_stop, soft_rst;
  logic [FN_W-1:0]   next_fn;
  logic [RES_W-1:0]  next_res, conv_res;
  logic [7:0]        filt;
  logic [1:0]        pin_fn;
  logic [REF_W-1:0]  ref_v;
  logic [CFG_W-1:0]  cfg_v;
  logic              en, busy;
  logic [FLAG_W-1:0] flags, flag_clr;
  logic [OFF_W-1:0]  off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pen_q <= 1'b0;
    else          pen_q <= pen_in;
  end

  assign off      = addr[OFF_W-1:0];
  assign flag_clr = (rd_en && !addr[OFF_W]) ? clear_of(off) : '0;

  tcc_regs #(.REF_W(REF_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .host_q(host), .fn_q(next_fn), .res_q(next_res), .filt_q(filt),
    .pin_fn_q(pin_fn), .ref_q(ref_v), .cfg_q(cfg_v),
    .ctl_wr(ctl_wr), .ctl_stop(ctl_stop), .soft_rst(soft_rst)
  );

  tcc_sequencer #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_i_n), .pen(pen_q), .next_fn(next_fn), .next_res(next_res),
    .ctl_wr(ctl_wr), .ctl_stop(ctl_stop), .soft_rst(soft_rst), .flag_clr(flag_clr),
    .en_q(en), .busy_q(busy), .res_q(conv_res), .flags_q(flags)
  );

  tcc_irq u_irq (
    .pen(pen_q), .en(en), .any_flag(|flags), .pin_fn(pin_fn), .irq_n(irq_n)
  );

  always_comb begin
    rdata = ALL_ONES;
    if (addr[OFF_W]) begin
      case (off)
        4'd0: rdata = {pen_q, !busy, next_fn, next_res, filt};
        4'd1: rdata = {pin_fn, !en, host, |flags, flags};
        4'd3: rdata = WORD_W'(ref_v);
        4'd5: rdata = WORD_W'(cfg_v);
        default: rdata = ALL_ONES;
      endcase
    end else begin
      case (off)
        4'd4, 4'd8, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15: rdata = ALL_ONES;
        default: rdata = sample_in >> shift_of(conv_res);
      endcase
    end
  end

  p_irq_quiet_when_disabled_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !en |-> irq_n);
endmodule

// File: tb/touch_conv_ctrl_tb.sv
module touch_conv_ctrl_tb;
  localparam int CONV = 8;
  localparam logic [4:0] A_CTL = 5'h10, A_STAT = 5'h11, A_REF = 5'h13,
                         A_RST = 5'h14, A_CFG = 5'h15;
  // {fn[16:13], pen[12], flags[11:1], enable_after[0]}
  localparam logic [16:0] VEC [16] = '{
    {4'd1,  1'b1, 11'h600, 1'b1},
    {4'd2,  1'b1, 11'h780, 1'b1},
    {4'd3,  1'b1, 11'h400, 1'b0},
    {4'd4,  1'b1, 11'h200, 1'b0},
    {4'd5,  1'b1, 11'h180, 1'b0},
    {4'd6,  1'b0, 11'h040, 1'b0},
    {4'd7,  1'b0, 11'h030, 1'b0},
    {4'd8,  1'b0, 11'h010, 1'b0},
    {4'd9,  1'b0, 11'h010, 1'b1},
    {4'd10, 1'b0, 11'h004, 1'b0},
    {4'd11, 1'b0, 11'h070, 1'b1},
    {4'd12, 1'b0, 11'h002, 1'b0},
    {4'd0,  1'b1, 11'h000, 1'b1},
    {4'd13, 1'b1, 11'h000, 1'b1},
    {4'd3,  1'b0, 11'h000, 1'b1},
    {4'd1,  1'b0, 11'h000, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pen_in = 1'b0;
  logic [15:0] sample_in = 16'hABCD;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  touch_conv_ctrl #(.CONV_CYCLES(CONV)) u_dut (
    .clk(clk), .rst_n(rst_n), .pen_in(pen_in), .sample_in(sample_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [15:0] ctl_word(input logic [3:0] fn, input logic [1:0] res,
                                           input logic stop, input logic host, input logic [7:0] filt);
    return {host, stop, fn, res, filt};
  endfunction

  function automatic logic [15:0] stat_word(input logic [1:0] pf, input logic en,
                                            input logic host, input logic [10:0] fl);
    return {pf, ~en, host, |fl, fl};
  endfunction

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fresh(input logic pen);
    wr(A_RST, 16'hBB00);
    pen_in = pen;
    wait_cyc(2);
  endtask

  initial begin
    logic [15:0] v;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    rd(A_STAT, v); check("R1 status", v, 16'hA000);
    rd(A_CTL, v);  check("R1 control", v, 16'h4000);
    check("R1 irq_n", {15'd0, irq_n}, 16'd1);

    // R4 R5 R6 table walk
    for (int i = 0; i < 16; i++) begin
      logic [3:0] fn;
      logic pen;
      logic [10:0] fl;
      logic en_after;
      {fn, pen, fl, en_after} = VEC[i];
      fresh(pen);
      wr(A_CTL, ctl_word(fn, 2'd0, 1'b0, 1'b0, 8'h00));
      wait_cyc(CONV + 4);
      rd(A_STAT, v);
      check($sformatf("R4/R5/R6 vector %0d fn %0d", i, fn), v, stat_word(2'd2, en_after, 1'b0, fl));
    end

    // R7 start timing
    fresh(1'b0);
    wr(A_CTL, ctl_word(4'd6, 2'd0, 1'b0, 1'b0, 8'h00));
    @(negedge clk);
    rd(A_CTL, v); check("R7 busy after start", {15'd0, v[14]}, 16'd0);
    wait_cyc(CONV - 2);
    rd(A_STAT, v); check("R7 no flags before end", v, stat_word(2'd2, 1'b1, 1'b0, 11'h0));
    rd(A_STAT, v); check("R7 flags at end", {5'd0, v[10:0]}, 16'h0040);

    // R9 resolution and R8 clear on read
    for (int r = 0; r < 4; r++) begin
      logic [15:0] exp;
      fresh(1'b0);
      wr(A_CTL, ctl_word(4'd6, 2'(r), 1'b0, 1'b0, 8'h00));
      wait_cyc(CONV + 4);
      exp = (r == 1) ? 16'h00AB : (r == 2) ? 16'h02AF : 16'h0ABC;
      rd(5'h05, v); check($sformatf("R9 resolution %0d", r), v, exp);
      rd(A_STAT, v); check("R8 offset 5 clears bit 6", {5'd0, v[10:0]}, 16'h0000);
    end
    rd(5'h04, v); check("R9 offset 4 reads ones", v, 16'hFFFF);
    rd(5'h08, v); check("R9 offset 8 reads ones", v, 16'hFFFF);

    fresh(1'b0);
    wr(A_CTL, ctl_word(4'd7, 2'd0, 1'b0, 1'b0, 8'h00));
    wait_cyc(CONV + 4);
    rd(5'h06, v);
    rd(A_STAT, v); check("R8 offset 6 clears bit 5", {5'd0, v[10:0]}, 16'h0010);
    rd(5'h07, v);
    rd(A_STAT, v); check("R8 offset 7 clears bit 4", {5'd0, v[10:0]}, 16'h0000);

    fresh(1'b1);
    wr(A_CTL, ctl_word(4'd3, 2'd0, 1'b0, 1'b0, 8'h00));
    wait_cyc(CONV + 4);
    rd(5'h04, v);
    rd(A_STAT, v); check("R8 offset 4 clears nothing", {5'd0, v[10:0]}, 16'h0400);
    rd(5'h00, v);
    rd(A_STAT, v); check("R8 offset 0 clears bit 10", {5'd0, v[10:0]}, 16'h0000);

    // R10 interrupt pin functions
    fresh(1'b1);
    check("R10 disabled irq high", {15'd0, irq_n}, 16'd1);
    wr(A_CTL, ctl_word(4'd0, 2'd0, 1'b0, 1'b0, 8'h00));
    @(negedge clk);
    check("R10 fn2 pen no flags", {15'd0, irq_n}, 16'd0);
    wr(A_STAT, 16'h0000);
    @(negedge clk);
    check("R10 fn0 pen down", {15'd0, irq_n}, 16'd0);
    pen_in = 1'b0; wait_cyc(2);
    check("R10 fn0 pen up", {15'd0, irq_n}, 16'd1);
    wr(A_STAT, 16'h4000);
    @(negedge clk);
    check("R10 fn1 no flags", {15'd0, irq_n}, 16'd1);
    wr(A_CTL, ctl_word(4'd9, 2'd0, 1'b0, 1'b0, 8'h00));
    wait_cyc(CONV + 4);
    check("R10 fn1 flag set", {15'd0, irq_n}, 16'd0);
    pen_in = 1'b1;
    wr(A_STAT, 16'h8000);
    @(negedge clk);
    check("R10 fn2 pen with flag", {15'd0, irq_n}, 16'd1);
    wr(A_CTL, ctl_word(4'd0, 2'd0, 1'b0, 1'b0, 8'h00));
    wait_cyc(CONV + 4);
    wr(A_STAT, 16'hC000);
    rd(5'h07, v);
    @(negedge clk);
    check("R10 fn3 pen flags cleared", {15'd0, irq_n}, 16'd0);

    // R2 R3 control and status layout
    fresh(1'b1);
    wr(A_CTL, 16'h825A);
    rd(A_CTL, v);  check("R2 control readback", v, 16'hC25A);
    rd(A_STAT, v); check("R3 status host bit", v, 16'h9000);

    // R13 field widths
    wr(A_REF, 16'hFFFF); rd(A_REF, v); check("R13 reference width", v, 16'h001F);
    wr(A_CFG, 16'hFFFF); rd(A_CFG, v); check("R13 configuration width", v, 16'h003F);

    // R11 soft reset key
    wr(A_RST, 16'h1234);
    rd(A_STAT, v); check("R11 wrong key ignored", v, 16'h9000);
    rd(A_REF, v);  check("R11 wrong key keeps reference", v, 16'h001F);
    wr(A_RST, 16'hBB00);
    rd(A_STAT, v); check("R11 key restores status", v, 16'hA000);
    rd(A_REF, v);  check("R11 key clears reference", v, 16'h0000);

    // R12 stop cancels running conversion
    fresh(1'b0);
    wr(A_CTL, ctl_word(4'd6, 2'd0, 1'b0, 1'b0, 8'h00));
    wait_cyc(2);
    wr(A_CTL, ctl_word(4'd6, 2'd0, 1'b1, 1'b0, 8'h00));
    wait_cyc(CONV + 4);
    rd(A_STAT, v); check("R12 no flags after stop", v, 16'hA000);
    rd(A_CTL, v);  check("R12 idle after stop", v, 16'h5800);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule